// File: doc/BRIEF.md
# SPI Status Flag Keeper

This block holds the status flags of a serial peripheral interface controller and presents them as a single 32-bit read-only status word at register offset 0x10. It does not move any data. It watches event strobes from the serial engine and host access strobes, and it keeps one flag for each condition software needs to poll. The engine strobes are transfer start, shifter load from the transmit holding register, receive word ready, shifter idle, the select-line level and mode-fault detect. The host strobes are enable and disable commands, writes to the transmit holding register, reads of the receive register and reads of the status word.

The flags do not all clear in the same way. The error and event flags are sticky and clear when the status word is read. Receive-full clears on a read of the receive register. Transmit-ready and transmit-empty follow the state of the transmit path. Transmit-empty also waits out a configurable number of cycles after the transmit path drains before it asserts. A status read returns the flags as they stood before the read clears them. When a set event and a clearing access fall in the same cycle, the set wins, so no event is lost. The select input is asynchronous and passes through a synchronizer before its rising edge is detected.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset the status word reads 0x00000000. Bits other than 0, 1, 2, 3, 8, 9, 10 and 16 always read 0.
- R2: Bit 16 (enabled) reads 1 from the edge that samples `cmd_en`. It reads 0 from the edge that samples `cmd_dis`. If both are sampled at the same edge, disable wins.
- R3: Bit 10 (underrun) is set at the edge that samples `ev_xfer_start` while `slave_mode`=1 and the transmit holding register holds no value. It stays 0 when `slave_mode`=0 or when a value is held. It clears on a status read.
- R4: Bit 9 (transmit-empty) requires three things: the block is enabled, the holding register is empty and `shift_idle`=1. With `dly_cfg`=D, the bit becomes 1 on the (D+1)-th consecutive edge at which this holds. Any edge at which it does not hold clears the bit and restarts the count.
- R5: A holding-register write (`host_wr_thr`) clears bit 9 at the edge that samples it.
- R6: Bit 8 (select-rising) becomes 1 at the third edge after `sel_in` rises (a two-stage synchronizer followed by an edge compare). It clears on a status read.
- R7: Bit 3 (overrun) is set when `ev_rx_ready` arrives while bit 0 is 1 and `host_rd_rxr` is not asserted in the same cycle. It clears on a status read.
- R8: Bit 2 (mode-fault) is set by `ev_mode_fault` and clears on a status read.
- R9: Bit 1 (transmit-ready) is 0 after reset and whenever bit 16 is 0. It goes to 0 on a holding-register write. It goes to 1 on the enable command, or on `ev_load_shifter` while enabled. A write wins over a load or an enable in the same cycle.
- R10: Bit 0 (receive-full) is set by `ev_rx_ready` and cleared by `host_rd_rxr`. The set wins if both occur in the same cycle.
- R11: In the cycle `host_rd_stat` is high, the status word still shows the pre-clear flags. A read-clear flag whose set event coincides with the read ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Enable command strobe |
| cmd_dis | input | 1 | Disable command strobe |
| slave_mode | input | 1 | 1 when the controller runs as slave |
| host_wr_thr | input | 1 | Host write to transmit holding register |
| host_rd_rxr | input | 1 | Host read of receive register |
| host_rd_stat | input | 1 | Host read of the status word |
| ev_xfer_start | input | 1 | Serial transfer begins |
| ev_load_shifter | input | 1 | Holding register moved into shifter |
| ev_rx_ready | input | 1 | Received word moved to receive register |
| shift_idle | input | 1 | Level: shifter holds no data |
| sel_in | input | 1 | Asynchronous slave-select level |
| ev_mode_fault | input | 1 | Mode-fault detect strobe |
| dly_cfg | input | DLY_W | Post-transfer delay in cycles |
| stat_word | output | 32 | Status word |

## Verification
The bench builds the block with `DLY_W`=3 and `SYNC_STAGES`=2. This keeps every transmit-empty delay from 0 to 7 within reach of a complete sweep, together with an interrupted count. For the sticky and receive flags, the bench applies every combination of prior flag state, set event and clearing access. This covers each same-cycle collision between a set and a clear. It also sweeps slave/master mode against holding-register state for underrun, and checks the select edge latency at exact cycle counts.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W    = 32;
  localparam logic [7:0] STAT_OFFSET = 8'h10;
  // Bit positions of the status word (software decodes these)
  localparam int BIT_RXF   = 0;
  localparam int BIT_TXR   = 1;
  localparam int BIT_MODF  = 2;
  localparam int BIT_OVR   = 3;
  localparam int BIT_SELR  = 8;
  localparam int BIT_TXE   = 9;
  localparam int BIT_UNDR  = 10;
  localparam int BIT_ENS   = 16;
  // Sticky flag slots inside the flag bank
  localparam int STK_UNDR  = 0;
  localparam int STK_SELR  = 1;
  localparam int STK_OVR   = 2;
  localparam int STK_MODF  = 3;
  localparam int N_STK     = 4;
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_STK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R11
  AST_STK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R11
endmodule

// File: rtl/spi_sel_edge.sv
module spi_sel_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_in,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = sel_in;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_SEL_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/spi_txe_timer.sv
module spi_txe_timer #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_i,
  input  logic             wr_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             txe_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic txe_q, txe_d;
  logic run;
  logic cnt_en;

  assign run    = cond_i & ~wr_i;
  assign cnt_en = run & (cnt_q < dly_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    txe_d = txe_q;
    if (!run)                txe_d = 1'b0;
    else if (cnt_q >= dly_i) txe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      txe_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      txe_q <= txe_d;
    end
  end

  assign txe_o = txe_q;

  AST_TXE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !txe_o); // R5
  AST_TXE_COND_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> !txe_o); // R4
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int DLY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              slave_mode,
  input  logic              host_wr_thr,
  input  logic              host_rd_rxr,
  input  logic              host_rd_stat,
  input  logic              ev_xfer_start,
  input  logic              ev_load_shifter,
  input  logic              ev_rx_ready,
  input  logic              shift_idle,
  input  logic              sel_in,
  input  logic              ev_mode_fault,
  input  logic [DLY_W-1:0]  dly_cfg,
  output logic [STAT_W-1:0] stat_word
);
  logic en_q, en_d;
  logic txr_q, txr_d;
  logic thr_full_q, thr_full_d;
  logic rxf_q, rxf_d;
  logic sel_rise;
  logic txe;
  logic txe_cond;
  logic [N_STK-1:0] stk_set, stk_q;

  // Enable state: disable has priority
  always_comb begin
    en_d = en_q;
    if (cmd_dis)     en_d = 1'b0;
    else if (cmd_en) en_d = 1'b1;
  end

  // Holding register occupancy
  always_comb begin
    thr_full_d = thr_full_q;
    if (cmd_dis)              thr_full_d = 1'b0;
    else if (host_wr_thr)     thr_full_d = 1'b1;
    else if (ev_load_shifter) thr_full_d = 1'b0;
  end

  // Transmit-ready: write beats load/enable, disable beats all
  always_comb begin
    txr_d = txr_q;
    if (cmd_dis)                              txr_d = 1'b0;
    else if (host_wr_thr)                     txr_d = 1'b0;
    else if (cmd_en || (ev_load_shifter && en_q)) txr_d = 1'b1;
  end

  // Receive-full: set wins over read
  always_comb begin
    rxf_d = rxf_q;
    if (ev_rx_ready)      rxf_d = 1'b1;
    else if (host_rd_rxr) rxf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      txr_q      <= 1'b0;
      thr_full_q <= 1'b0;
      rxf_q      <= 1'b0;
    end else begin
      en_q       <= en_d;
      txr_q      <= txr_d;
      thr_full_q <= thr_full_d;
      rxf_q      <= rxf_d;
    end
  end

  spi_sel_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_in (sel_in),
    .rise_o (sel_rise)
  );

  assign txe_cond = en_q & ~thr_full_q & shift_idle;

  spi_txe_timer #(.DLY_W(DLY_W)) u_txe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (txe_cond),
    .wr_i   (host_wr_thr),
    .dly_i  (dly_cfg),
    .txe_o  (txe)
  );

  assign stk_set[STK_UNDR] = ev_xfer_start & slave_mode & ~thr_full_q & ~host_wr_thr;
  assign stk_set[STK_SELR] = sel_rise;
  assign stk_set[STK_OVR]  = ev_rx_ready & rxf_q & ~host_rd_rxr;
  assign stk_set[STK_MODF] = ev_mode_fault;

  generate
    for (genvar k = 0; k < N_STK; k++) begin : g_stk
      spi_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set[k]),
        .clr_i  (host_rd_stat),
        .flag_o (stk_q[k])
      );
    end
  endgenerate

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_RXF]  = rxf_q;
    stat_word[BIT_TXR]  = txr_q;
    stat_word[BIT_MODF] = stk_q[STK_MODF];
    stat_word[BIT_OVR]  = stk_q[STK_OVR];
    stat_word[BIT_SELR] = stk_q[STK_SELR];
    stat_word[BIT_TXE]  = txe;
    stat_word[BIT_UNDR] = stk_q[STK_UNDR];
    stat_word[BIT_ENS]  = en_q;
  end

  AST_EN_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis |=> !stat_word[BIT_ENS]); // R2
  AST_TXR_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_word[BIT_ENS] |-> !stat_word[BIT_TXR]); // R9
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ready |=> stat_word[BIT_RXF]); // R10
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_ready && stat_word[BIT_RXF] && !host_rd_rxr) |=> stat_word[BIT_OVR]); // R7
  AST_UNDR_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !stat_word[BIT_UNDR]) |=> (!stat_word[BIT_UNDR] || $past(slave_mode))); // R3
endmodule

// File: tb/tb_spi_stat_flags.sv
`timescale 1ns/1ps
module tb_spi_stat_flags;
  logic clk = 1'b0;
  logic rst_n, cmd_en, cmd_dis, slave_mode, host_wr_thr, host_rd_rxr, host_rd_stat;
  logic ev_xfer_start, ev_load_shifter, ev_rx_ready, shift_idle, sel_in, ev_mode_fault;
  logic [2:0] dly_cfg;
  logic [31:0] stat_word;
  int nvec = 0;
  int nerr = 0;
  bit done = 0;
  localparam logic [31:0] USED = 32'h0001_070F;

  always #2 clk = ~clk;

  spi_stat_flags #(.DLY_W(3), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .slave_mode(slave_mode), .host_wr_thr(host_wr_thr), .host_rd_rxr(host_rd_rxr),
    .host_rd_stat(host_rd_stat), .ev_xfer_start(ev_xfer_start),
    .ev_load_shifter(ev_load_shifter), .ev_rx_ready(ev_rx_ready),
    .shift_idle(shift_idle), .sel_in(sel_in), .ev_mode_fault(ev_mode_fault),
    .dly_cfg(dly_cfg), .stat_word(stat_word));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_stat();
    host_rd_stat = 1; tick(); host_rd_stat = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_en = 0; cmd_dis = 0; slave_mode = 0; host_wr_thr = 0;
    host_rd_rxr = 0; host_rd_stat = 0; ev_xfer_start = 0; ev_load_shifter = 0;
    ev_rx_ready = 0; shift_idle = 0; sel_in = 0; ev_mode_fault = 0; dly_cfg = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset word", stat_word, 32'h0);

    // R2 / R9: enable
    cmd_en = 1; tick(); cmd_en = 0;
    chk("R2 enabled bit16", {31'b0, stat_word[16]}, 1);
    chk("R9 ready after enable", {31'b0, stat_word[1]}, 1);

    // R4 / R5 / R9: transmit-empty delay sweep
    for (int d = 0; d < 8; d++) begin
      int n;
      dly_cfg = 3'(d); shift_idle = 1; n = 0;
      do begin tick(); n++; end while (!stat_word[9] && n < 20);
      chk("R4 txe delay edges", 32'(n), 32'(d + 1));
      shift_idle = 0; host_wr_thr = 1; tick(); host_wr_thr = 0;
      chk("R5 write clears txe", {31'b0, stat_word[9]}, 0);
      chk("R9 write clears ready", {31'b0, stat_word[1]}, 0);
      ev_load_shifter = 1; tick(); ev_load_shifter = 0;
      chk("R9 load sets ready", {31'b0, stat_word[1]}, 1);
    end
    begin
      int n;
      dly_cfg = 3'd5; shift_idle = 1;
      repeat (3) tick();
      shift_idle = 0; tick();
      chk("R4 txe low after drop", {31'b0, stat_word[9]}, 0);
      shift_idle = 1; n = 0;
      do begin tick(); n++; end while (!stat_word[9] && n < 20);
      chk("R4 restarted count", 32'(n), 32'd6);
      shift_idle = 0; tick();
      chk("R4 txe cleared on idle loss", {31'b0, stat_word[9]}, 0);
    end

    // R3: underrun, slave mode x holding state
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 2; f++) begin
        slave_mode = s[0];
        if (f != 0) begin host_wr_thr = 1; tick(); host_wr_thr = 0; end
        rd_stat();
        ev_xfer_start = 1; tick(); ev_xfer_start = 0;
        chk("R3 underrun set rule", {31'b0, stat_word[10]}, {31'b0, (s == 1) && (f == 0)});
        rd_stat();
        chk("R3 underrun read clear", {31'b0, stat_word[10]}, 0);
        if (f != 0) begin ev_load_shifter = 1; tick(); ev_load_shifter = 0; end
      end
    end
    slave_mode = 0;

    // R6: select rising edge latency
    rd_stat();
    sel_in = 1;
    tick(); tick();
    chk("R6 no flag after two edges", {31'b0, stat_word[8]}, 0);
    tick();
    chk("R6 flag at third edge", {31'b0, stat_word[8]}, 1);
    sel_in = 0; rd_stat();
    chk("R6 read clears", {31'b0, stat_word[8]}, 0);
    repeat (4) tick();
    chk("R6 falling edge no set", {31'b0, stat_word[8]}, 0);

    // R7 / R10: receive-full and overrun, all combinations
    for (int r = 0; r < 2; r++) begin
      for (int y = 0; y < 2; y++) begin
        for (int q = 0; q < 2; q++) begin
          host_rd_rxr = 1; host_rd_stat = 1; tick(); host_rd_rxr = 0; host_rd_stat = 0;
          if (r != 0) begin ev_rx_ready = 1; tick(); ev_rx_ready = 0; end
          ev_rx_ready = y[0]; host_rd_rxr = q[0]; tick();
          ev_rx_ready = 0; host_rd_rxr = 0;
          chk("R10 receive-full", {31'b0, stat_word[0]},
              {31'b0, (y == 1) || ((r == 1) && (q == 0))});
          chk("R7 overrun", {31'b0, stat_word[3]},
              {31'b0, (y == 1) && (r == 1) && (q == 0)});
        end
      end
    end
    rd_stat();
    chk("R7 overrun read clear", {31'b0, stat_word[3]}, 0);

    // R8 / R11: mode fault with collisions
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 2; c++) begin
          if (p != 0) begin ev_mode_fault = 1; tick(); ev_mode_fault = 0; end
          else rd_stat();
          ev_mode_fault = m[0]; host_rd_stat = c[0];
          #1;
          chk("R11 pre-clear view", {31'b0, stat_word[2]}, 32'(p));
          tick();
          ev_mode_fault = 0; host_rd_stat = 0;
          chk("R8 mode-fault next", {31'b0, stat_word[2]},
              {31'b0, (m == 1) || ((p == 1) && (c == 0))});
        end
      end
    end
    chk("R1 reserved bits zero", stat_word & ~USED, 32'h0);

    // R2 / R9: disable priority
    cmd_dis = 1; tick(); cmd_dis = 0;
    chk("R2 disable clears bit16", {31'b0, stat_word[16]}, 0);
    chk("R9 ready low when disabled", {31'b0, stat_word[1]}, 0);
    cmd_en = 1; cmd_dis = 1; tick(); cmd_en = 0; cmd_dis = 0;
    chk("R2 disable wins", {31'b0, stat_word[16]}, 0);
    cmd_en = 1; host_wr_thr = 1; tick(); cmd_en = 0; host_wr_thr = 0;
    chk("R2 enable", {31'b0, stat_word[16]}, 1);
    chk("R9 write beats enable", {31'b0, stat_word[1]}, 0);
    chk("R1 reserved bits zero end", stat_word & ~USED, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule